// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is a behavioural controller for a nonvolatile array that is split into equal blocks, each of which can be erased on its own. Storage is modelled as a small register array that stands in for the cells. Erase, program and lock-bit times are programmable cycle counts rather than real cell physics. A host issues commands on a simple bus. Every modifying command takes two bus cycles: a setup code, then a confirm or data cycle. Suspend, resume and clear-status each take a single cycle. The low eight bits of the data bus carry the command code.

The sequencer can program a word, erase a block, and set or clear a block's lock bit. A running erase or program can be suspended and later resumed from where it stopped. While an erase is suspended, the host may read or program any other block. While a program is suspended, the host may read any block except the one being programmed. A ready/busy output and an 8-bit status register report progress and sticky error flags. An enable-voltage input, modelled as a digital level, refuses or aborts every modifying operation while it is low.

Top module: `flash_seq`

## Requirements
- R1: After reset, every word reads all ones, no block is locked, `stsReady` is 1 and `statusReg` is 8'h80. Status bits are: [7] ready, [6] erase suspended, [5] erase failed, [4] program or lock-bit op failed, [3] lockout, [2] program suspended, [1] locked-block hit, [0] command-sequence error.
- R2: A program or erase confirm aimed at a locked block is refused. It sets bit 1 together with bit 4 (program) or bit 5 (erase), leaves the array unchanged, and `stsReady` stays 1.
- R3: While `vppOk` is 0, any program, erase or lock-bit confirm is refused and sets bit 3 and the fail bit of that operation. If `vppOk` is 0 at a clock edge while an operation is running, that operation is aborted in that edge without writing, and the same bits are set.
- R4: `stsReady` is 0 for exactly PROG_CYCLES, ERASE_CYCLES or LOCK_CYCLES cycles after the confirm edge. Each accepted suspend edge adds one cycle to this count.
- R5: Program is setup code 8'h40 followed by a data cycle. It stores old AND data at the address.
- R6: Erase is 8'h20 then 8'hD0, with the block taken from the upper address bits. It sets every word of that block to all ones and leaves the other blocks untouched.
- R7: Lock-bit commands are 8'h60 then 8'h01 to set the lock, or 8'h60 then 8'hD0 to clear it. They are accepted only when the sequencer is ready and not suspended.
- R8: Code 8'hB0 during an erase suspends it at the next edge: `stsReady` goes 1 and bit 6 is set. Reads of the erased block are then denied and reads of other blocks are served. A program to another block runs and then returns to the erase-suspended state.
- R9: Code 8'hB0 during a program suspends it at the next edge and sets bit 2. Reads of that program's block are denied.
- R10: Code 8'hD0 while suspended resumes the operation with its remaining cycle count, and `stsReady` goes low again.
- R11: A wrong confirm code, an unknown first code, or a command that is not allowed in the current state sets bit 0 and starts nothing.
- R12: Error bits stay set across later commands until code 8'h50 is issued while the sequencer is not running.
- R13: A read (`rdEn`) returns `rdData` and `rdDenied` one cycle later. The read is denied, returning zero, while an operation runs.
- R14: While an operation runs, every command other than suspend is ignored. A suspend arriving on the final cycle of an operation is also ignored, and the operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Bus command cycle strobe |
| cmdAddr | input | ADDR_W | Word address; upper bits select the block |
| cmdData | input | DATA_W | Command code in [7:0], or program data |
| vppOk | input | 1 | Enable-voltage level; 0 means lockout |
| rdEn | input | 1 | Array read request |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | DATA_W | Read data, valid one cycle after rdEn |
| rdDenied | output | 1 | Read refused, valid with rdData |
| stsReady | output | 1 | 1 when ready or suspended, 0 while running |
| statusReg | output | 8 | Status and sticky error bits |

## Verification
A command cycle presented before edge E is acted on at E. Its effect on `stsReady` and `statusReg` is visible at the falling edge just after E. A completed write becomes readable through a read issued after the completion edge, with data visible one cycle later. A behavioural model in the bench advances at each rising edge, using the same inputs the design sees. Ready, status and read results are compared at every falling edge, when the registered outputs have settled. Directed scenario checks count busy cycles between falling edges, which checks the exact operation lengths, including the remaining count after a suspend.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] CodeProgSetup  = 8'h40;
  localparam logic [7:0] CodeEraseSetup = 8'h20;
  localparam logic [7:0] CodeLockSetup  = 8'h60;
  localparam logic [7:0] CodeConfirm    = 8'hD0;
  localparam logic [7:0] CodeLockSet    = 8'h01;
  localparam logic [7:0] CodeSuspend    = 8'hB0;
  localparam logic [7:0] CodeResume     = 8'hD0;
  localparam logic [7:0] CodeClrStat    = 8'h50;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PSUSP, ST_ESUSP} seqState_t;
  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_LOCKSET, OP_LOCKCLR} opKind_t;
  typedef enum logic [1:0] {PEND_NONE, PEND_PROG, PEND_ERASE, PEND_LOCK} pend_t;

  typedef struct packed {
    logic wrProg;
    logic wrErase;
    logic setLock;
    logic clrLock;
    logic busy;
    logic protValid;
  } seqStrobe_t;
endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_WORDS  = 16,
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20,
  parameter int LOCK_CYCLES  = 4,
  parameter int ADDR_W       = $clog2(NUM_BLOCKS * BLOCK_WORDS),
  parameter int BLK_W        = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              vppOk,
  input  logic [NUM_BLOCKS-1:0] lockBits,
  output seqStrobe_t        strb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [BLK_W-1:0]  protBlock,
  output logic              stsReady,
  output logic [7:0]        statusReg
);
  localparam int MaxPE  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MaxCyc = (MaxPE > LOCK_CYCLES) ? MaxPE : LOCK_CYCLES;
  localparam int CNT_W  = $clog2(MaxCyc + 1);
  localparam int WIDX_W = ADDR_W - BLK_W;

  seqState_t state;
  pend_t     pend;
  opKind_t   curOp;
  logic [CNT_W-1:0] cnt, susCnt;
  logic [BLK_W-1:0] susBlock;
  logic nested;
  logic errSeq, errLocked, errLockout, errProg, errErase;

  logic [7:0]       cmdCode;
  logic [BLK_W-1:0] cmdBlk, opBlk;
  logic done;

  assign cmdCode = cmdData[7:0];
  assign cmdBlk  = cmdAddr[ADDR_W-1 -: BLK_W];
  assign opBlk   = opAddr[ADDR_W-1 -: BLK_W];
  assign done    = (state == ST_RUN) && (cnt == CNT_W'(1)) && vppOk;

  always_comb begin
    strb.wrProg    = done && (curOp == OP_PROG);
    strb.wrErase   = done && (curOp == OP_ERASE);
    strb.setLock   = done && (curOp == OP_LOCKSET);
    strb.clrLock   = done && (curOp == OP_LOCKCLR);
    strb.busy      = (state == ST_RUN);
    strb.protValid = (state == ST_PSUSP) || (state == ST_ESUSP) || nested;
    protBlock      = ((state == ST_ESUSP) || nested) ? susBlock : opBlk;
  end

  assign stsReady  = (state != ST_RUN);
  assign statusReg = {stsReady, (state == ST_ESUSP) || nested, errErase, errProg,
                      errLockout, (state == ST_PSUSP), errLocked, errSeq};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pend       <= PEND_NONE;
      curOp      <= OP_PROG;
      cnt        <= '0;
      susCnt     <= '0;
      susBlock   <= '0;
      nested     <= 1'b0;
      opAddr     <= '0;
      opData     <= '0;
      errSeq     <= 1'b0;
      errLocked  <= 1'b0;
      errLockout <= 1'b0;
      errProg    <= 1'b0;
      errErase   <= 1'b0;
    end else if (state == ST_RUN) begin
      if (!vppOk) begin
        errLockout <= 1'b1;
        if (curOp == OP_ERASE) errErase <= 1'b1;
        else                   errProg  <= 1'b1;
        state  <= nested ? ST_ESUSP : ST_IDLE;
        nested <= 1'b0;
      end else if (cnt == CNT_W'(1)) begin
        state  <= nested ? ST_ESUSP : ST_IDLE;
        nested <= 1'b0;
      end else if (cmdValid && cmdCode == CodeSuspend && !nested &&
                   (curOp == OP_PROG || curOp == OP_ERASE)) begin
        if (curOp == OP_ERASE) begin
          state    <= ST_ESUSP;
          susCnt   <= cnt;
          susBlock <= opBlk;
        end else begin
          state <= ST_PSUSP;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end else if (cmdValid) begin
      case (pend)
        PEND_NONE: begin
          if (cmdCode == CodeClrStat) begin
            errSeq <= 1'b0; errLocked <= 1'b0; errLockout <= 1'b0;
            errProg <= 1'b0; errErase <= 1'b0;
          end else if (cmdCode == CodeResume && state == ST_PSUSP) begin
            state <= ST_RUN;
          end else if (cmdCode == CodeResume && state == ST_ESUSP) begin
            state  <= ST_RUN;
            curOp  <= OP_ERASE;
            cnt    <= susCnt;
            opAddr <= {susBlock, {WIDX_W{1'b0}}};
          end else if (cmdCode == CodeProgSetup && state != ST_PSUSP) begin
            pend <= PEND_PROG;
          end else if (cmdCode == CodeEraseSetup && state == ST_IDLE) begin
            pend <= PEND_ERASE;
          end else if (cmdCode == CodeLockSetup && state == ST_IDLE) begin
            pend <= PEND_LOCK;
          end else begin
            errSeq <= 1'b1;
          end
        end
        PEND_PROG: begin
          pend <= PEND_NONE;
          if (state == ST_ESUSP && cmdBlk == susBlock) begin
            errSeq <= 1'b1;
          end else if (!vppOk) begin
            errLockout <= 1'b1; errProg <= 1'b1;
          end else if (lockBits[cmdBlk]) begin
            errLocked <= 1'b1; errProg <= 1'b1;
          end else begin
            state  <= ST_RUN;
            curOp  <= OP_PROG;
            cnt    <= CNT_W'(PROG_CYCLES);
            opAddr <= cmdAddr;
            opData <= cmdData;
            nested <= (state == ST_ESUSP);
          end
        end
        PEND_ERASE: begin
          pend <= PEND_NONE;
          if (cmdCode != CodeConfirm) begin
            errSeq <= 1'b1;
          end else if (!vppOk) begin
            errLockout <= 1'b1; errErase <= 1'b1;
          end else if (lockBits[cmdBlk]) begin
            errLocked <= 1'b1; errErase <= 1'b1;
          end else begin
            state  <= ST_RUN;
            curOp  <= OP_ERASE;
            cnt    <= CNT_W'(ERASE_CYCLES);
            opAddr <= cmdAddr;
          end
        end
        default: begin
          pend <= PEND_NONE;
          if (cmdCode != CodeLockSet && cmdCode != CodeConfirm) begin
            errSeq <= 1'b1;
          end else if (!vppOk) begin
            errLockout <= 1'b1; errProg <= 1'b1;
          end else begin
            state  <= ST_RUN;
            curOp  <= (cmdCode == CodeLockSet) ? OP_LOCKSET : OP_LOCKCLR;
            cnt    <= CNT_W'(LOCK_CYCLES);
            opAddr <= cmdAddr;
          end
        end
      endcase
    end
  end

  // R3: a confirm cycle under lockout never starts an operation
  p_lockout_refuse_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !vppOk && state != ST_RUN && pend != PEND_NONE |=> state != ST_RUN);

  // R4: the last counted cycle always returns the ready output
  p_ready_after_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN && cnt == CNT_W'(1) |=> stsReady);

  // R8: an erase suspend takes effect at the very next edge
  p_erase_susp_fast_r8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RUN && vppOk && cnt != CNT_W'(1) && cmdValid && cmdCode == CodeSuspend &&
    !nested && curOp == OP_ERASE |=> stsReady && statusReg[6]);

  // R10: remaining program count is frozen while suspended
  p_prog_susp_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PSUSP |=> $stable(cnt));

  // R12: the sequence error flag only clears through the clear-status code
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    errSeq && !(cmdValid && state != ST_RUN && pend == PEND_NONE && cmdCode == CodeClrStat)
    |=> errSeq);
endmodule

// File: rtl/flash_seq_dpath.sv
module flash_seq_dpath
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_WORDS = 16,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = $clog2(NUM_BLOCKS * BLOCK_WORDS),
  parameter int BLK_W       = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [BLK_W-1:0]  protBlock,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDenied,
  output logic [NUM_BLOCKS-1:0] lockBits
);
  localparam int NUM_WORDS = NUM_BLOCKS * BLOCK_WORDS;
  localparam int WIDX_W    = ADDR_W - BLK_W;

  logic [DATA_W-1:0] mem [NUM_WORDS];
  logic [BLK_W-1:0]  opBlk, rdBlk;
  logic              denyNow;

  assign opBlk   = opAddr[ADDR_W-1 -: BLK_W];
  assign rdBlk   = rdAddr[ADDR_W-1 -: BLK_W];
  assign denyNow = strb.busy || (strb.protValid && rdBlk == protBlock);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '1;
    end else if (strb.wrProg) begin
      mem[opAddr] <= mem[opAddr] & opData;
    end else if (strb.wrErase) begin
      for (int w = 0; w < BLOCK_WORDS; w++) mem[{opBlk, WIDX_W'(w)}] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBits <= '0;
    end else if (strb.setLock) begin
      lockBits[opBlk] <= 1'b1;
    end else if (strb.clrLock) begin
      lockBits[opBlk] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      rdDenied <= 1'b0;
    end else if (rdEn) begin
      rdDenied <= denyNow;
      rdData   <= denyNow ? '0 : mem[rdAddr];
    end
  end

  // R2: no write ever reaches a locked block
  p_no_write_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrProg || strb.wrErase) |-> !lockBits[opBlk]);

  // R5: a program leaves no bit set that the data word had clear
  p_prog_clears_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrProg |=> ((mem[$past(opAddr)] & ~$past(opData)) == '0));

  // R6: the first word of an erased block reads all ones afterwards
  p_erase_ones_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrErase |=> (mem[{$past(opBlk), WIDX_W'(0)}] == '1));

  // R13: a read during a running operation is always denied
  p_read_busy_denied_r13: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && strb.busy |=> rdDenied && rdData == '0);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_WORDS  = 16,
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20,
  parameter int LOCK_CYCLES  = 4,
  parameter int ADDR_W       = $clog2(NUM_BLOCKS * BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              vppOk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDenied,
  output logic              stsReady,
  output logic [7:0]        statusReg
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  seqStrobe_t            strb;
  logic [ADDR_W-1:0]     opAddr;
  logic [DATA_W-1:0]     opData;
  logic [BLK_W-1:0]      protBlock;
  logic [NUM_BLOCKS-1:0] lockBits;

  flash_seq_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .LOCK_CYCLES(LOCK_CYCLES),
    .ADDR_W(ADDR_W), .BLK_W(BLK_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .vppOk(vppOk), .lockBits(lockBits), .strb(strb), .opAddr(opAddr), .opData(opData),
    .protBlock(protBlock), .stsReady(stsReady), .statusReg(statusReg)
  );

  flash_seq_dpath #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .BLK_W(BLK_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr), .opData(opData),
    .protBlock(protBlock), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdDenied(rdDenied), .lockBits(lockBits)
  );
endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
  localparam int NB = 4, BW = 16, DW = 16, AW = 6;
  localparam int PC = 6, EC = 20, LC = 4;
  localparam int NW = NB * BW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic vppOk = 1'b1;
  logic rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic rdDenied, stsReady;
  logic [7:0] statusReg;

  always #10 clk = ~clk;

  flash_seq #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .DATA_W(DW),
              .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .LOCK_CYCLES(LC)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .vppOk(vppOk), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdDenied(rdDenied),
    .stsReady(stsReady), .statusReg(statusReg));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 ready, 1 running, 2 program suspended, 3 erase suspended
  // pending: 0 none, 1 program, 2 erase, 3 lock ; op: 0 prog, 1 erase, 2 lock set, 3 lock clear
  int mMem[NW];
  bit mLock[NB];
  int mMode, mPend, mOp, mLeft, mAddr, mDat, mSLeft, mSBlk;
  bit mNest, eSeq, eLck, eVpp, eProg, eErs;
  int mRd;
  bit mRdDen;
  int code, blk, pb;

  function automatic logic [7:0] expStatus();
    return {mMode != 1, (mMode == 3) || mNest, eErs, eProg, eVpp, mMode == 2, eLck, eSeq};
  endfunction

  task automatic begin_op(int op, int left, int a, int d, bit nest);
    mMode = 1; mOp = op; mLeft = left; mAddr = a; mDat = d; mNest = nest;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 16'hFFFF;
      foreach (mLock[i]) mLock[i] = 0;
      mMode = 0; mPend = 0; mOp = 0; mLeft = 0; mAddr = 0; mDat = 0; mSLeft = 0; mSBlk = 0;
      mNest = 0; eSeq = 0; eLck = 0; eVpp = 0; eProg = 0; eErs = 0; mRd = 0; mRdDen = 0;
    end else begin
      code = int'(cmdData[7:0]);
      blk = int'(cmdAddr) / BW;
      if (rdEn) begin
        pb = ((mMode == 3) || mNest) ? mSBlk : mAddr / BW;
        mRdDen = (mMode == 1) || (((mMode >= 2) || mNest) && (int'(rdAddr) / BW == pb));
        mRd = mRdDen ? 0 : mMem[rdAddr];
      end
      if (mMode == 1) begin
        if (!vppOk) begin
          eVpp = 1;
          if (mOp == 1) eErs = 1; else eProg = 1;
          mMode = mNest ? 3 : 0; mNest = 0;
        end else if (mLeft == 1) begin
          case (mOp)
            0: mMem[mAddr] = mMem[mAddr] & mDat;
            1: for (int w = 0; w < BW; w++) mMem[(mAddr / BW) * BW + w] = 16'hFFFF;
            2: mLock[mAddr / BW] = 1;
            default: mLock[mAddr / BW] = 0;
          endcase
          mMode = mNest ? 3 : 0; mNest = 0;
        end else if (cmdValid && code == 8'hB0 && !mNest && mOp <= 1) begin
          if (mOp == 1) begin mMode = 3; mSLeft = mLeft; mSBlk = mAddr / BW; end
          else mMode = 2;
        end else mLeft--;
      end else if (cmdValid) begin
        if (mPend == 0) begin
          if (code == 8'h50) begin eSeq = 0; eLck = 0; eVpp = 0; eProg = 0; eErs = 0; end
          else if (code == 8'hD0 && mMode == 2) mMode = 1;
          else if (code == 8'hD0 && mMode == 3) begin_op(1, mSLeft, mSBlk * BW, 0, 0);
          else if (code == 8'h40 && mMode != 2) mPend = 1;
          else if (code == 8'h20 && mMode == 0) mPend = 2;
          else if (code == 8'h60 && mMode == 0) mPend = 3;
          else eSeq = 1;
        end else if (mPend == 1) begin
          mPend = 0;
          if (mMode == 3 && blk == mSBlk) eSeq = 1;
          else if (!vppOk) begin eVpp = 1; eProg = 1; end
          else if (mLock[blk]) begin eLck = 1; eProg = 1; end
          else begin_op(0, PC, int'(cmdAddr), int'(cmdData), mMode == 3);
        end else if (mPend == 2) begin
          mPend = 0;
          if (code != 8'hD0) eSeq = 1;
          else if (!vppOk) begin eVpp = 1; eErs = 1; end
          else if (mLock[blk]) begin eLck = 1; eErs = 1; end
          else begin_op(1, EC, int'(cmdAddr), 0, 0);
        end else begin
          mPend = 0;
          if (code != 8'h01 && code != 8'hD0) eSeq = 1;
          else if (!vppOk) begin eVpp = 1; eProg = 1; end
          else begin_op(code == 8'h01 ? 2 : 3, LC, int'(cmdAddr), 0, 0);
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(stsReady == (mMode != 1), "R4 ready vs model", 32'(stsReady), 32'(mMode != 1));
      check(statusReg == expStatus(), "R12 status vs model", 32'(statusReg), 32'(expStatus()));
      check(rdDenied == mRdDen, "R13 denied vs model", 32'(rdDenied), 32'(mRdDen));
      check(rdData == DW'(mRd), "R13 data vs model", 32'(rdData), 32'(mRd));
    end
  end

  // ---------------- stimulus helpers (start and end at a falling edge) ----------------
  task automatic bus(int a, int d);
    cmdValid = 1'b1; cmdAddr = AW'(a); cmdData = DW'(d);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic prog(int a, int d);
    bus(0, 8'h40); bus(a, d);
  endtask

  task automatic erase(int b);
    bus(0, 8'h20); bus(b * BW, 8'hD0);
  endtask

  task automatic busyCount(output int n);
    n = 0;
    while (!stsReady) begin n++; @(negedge clk); end
  endtask

  task automatic rd(int a);
    rdEn = 1'b1; rdAddr = AW'(a);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stsReady == 1'b1, "R1 ready after reset", 32'(stsReady), 1);
    check(statusReg == 8'h80, "R1 status after reset", 32'(statusReg), 32'h80);
    rd(0);
    check(rdData == 16'hFFFF, "R1 erased content", 32'(rdData), 32'hFFFF);

    // R4/R5 program and its length
    prog(5, 16'h0F0F);
    busyCount(n);
    check(n == PC, "R4 program length", 32'(n), 32'(PC));
    rd(5);
    check(rdData == 16'h0F0F, "R5 first program", 32'(rdData), 32'h0F0F);
    prog(5, 16'hFF00); busyCount(n);
    rd(5);
    check(rdData == 16'h0F00, "R5 program only clears", 32'(rdData), 32'h0F00);

    // R7 lock block 1, R2 refusals
    bus(0, 8'h60); bus(16, 8'h01);
    busyCount(n);
    check(n == LC, "R7 lock op length", 32'(n), 32'(LC));
    prog(17, 16'h0000);
    check(stsReady == 1'b1, "R2 stays ready on locked", 32'(stsReady), 1);
    check(statusReg == 8'h92, "R2 program locked block", 32'(statusReg), 32'h92);
    erase(1);
    check(statusReg == 8'hB2, "R2 erase locked block", 32'(statusReg), 32'hB2);
    rd(17);
    check(rdData == 16'hFFFF, "R2 locked word unchanged", 32'(rdData), 32'hFFFF);
    bus(0, 8'h50);
    check(statusReg == 8'h80, "R12 clear status", 32'(statusReg), 32'h80);
    bus(0, 8'h60); bus(16, 8'hD0); busyCount(n);
    prog(17, 16'h1111); busyCount(n);
    rd(17);
    check(rdData == 16'h1111, "R7 unlock then program", 32'(rdData), 32'h1111);

    // R11/R12 sequence errors are sticky
    bus(0, 8'h20); bus(0, 8'h33);
    check(statusReg == 8'h81, "R11 bad erase confirm", 32'(statusReg), 32'h81);
    prog(20, 16'h2222); busyCount(n);
    check(statusReg == 8'h81, "R12 error survives program", 32'(statusReg), 32'h81);
    bus(0, 8'h50);
    bus(0, 8'h77);
    check(statusReg == 8'h81, "R11 unknown code", 32'(statusReg), 32'h81);
    bus(0, 8'hB0);
    check(statusReg == 8'h81, "R11 suspend while ready", 32'(statusReg), 32'h81);
    bus(0, 8'h50);

    // R3 lockout refusal and abort
    prog(32, 16'h1234); busyCount(n);
    prog(48, 16'h00FF); busyCount(n);
    vppOk = 1'b0;
    prog(34, 16'h0000);
    check(statusReg == 8'h98, "R3 program refused under lockout", 32'(statusReg), 32'h98);
    bus(0, 8'h60); bus(0, 8'h01);
    check(stsReady == 1'b1, "R3 lock op refused under lockout", 32'(stsReady), 1);
    vppOk = 1'b1;
    bus(0, 8'h50);
    erase(2);
    repeat (3) @(negedge clk);
    vppOk = 1'b0;
    @(negedge clk);
    check(statusReg == 8'hA8, "R3 erase aborted", 32'(statusReg), 32'hA8);
    vppOk = 1'b1;
    rd(32);
    check(rdData == 16'h1234, "R3 aborted erase left data", 32'(rdData), 32'h1234);
    bus(0, 8'h50);

    // R6 erase one block only
    erase(2);
    busyCount(n);
    check(n == EC, "R4 erase length", 32'(n), 32'(EC));
    rd(32);
    check(rdData == 16'hFFFF, "R6 erased word", 32'(rdData), 32'hFFFF);
    rd(48);
    check(rdData == 16'h00FF, "R6 other block kept", 32'(rdData), 32'h00FF);

    // R8 erase suspend with nested program, R10 resume
    prog(33, 16'h0000); busyCount(n);
    erase(2);
    repeat (5) @(negedge clk);
    bus(0, 8'hB0);
    check(stsReady == 1'b1, "R8 ready when erase suspended", 32'(stsReady), 1);
    check(statusReg == 8'hC0, "R8 erase suspend bit", 32'(statusReg), 32'hC0);
    rd(33);
    check(rdDenied == 1'b1, "R8 suspended block denied", 32'(rdDenied), 1);
    rd(5);
    check(rdData == 16'h0F00 && !rdDenied, "R8 other block readable", 32'(rdData), 32'h0F00);
    prog(6, 16'h00F0);
    check(statusReg == 8'h40, "R8 nested program running", 32'(statusReg), 32'h40);
    busyCount(n);
    check(statusReg == 8'hC0, "R8 back to erase suspended", 32'(statusReg), 32'hC0);
    rd(6);
    check(rdData == 16'h00F0, "R8 nested program data", 32'(rdData), 32'h00F0);
    bus(0, 8'hD0);
    busyCount(n);
    check(n == EC - 5, "R10 erase remaining count", 32'(n), 32'(EC - 5));
    rd(33);
    check(rdData == 16'hFFFF, "R10 resumed erase finished", 32'(rdData), 32'hFFFF);

    // R9 program suspend, R10 resume
    prog(40, 16'h0000);
    repeat (2) @(negedge clk);
    bus(0, 8'hB0);
    check(statusReg == 8'h84, "R9 program suspend bit", 32'(statusReg), 32'h84);
    rd(40);
    check(rdDenied == 1'b1, "R9 suspended block denied", 32'(rdDenied), 1);
    rd(5);
    check(rdDenied == 1'b0, "R9 other block served", 32'(rdDenied), 0);
    bus(0, 8'hD0);
    busyCount(n);
    check(n == PC - 2, "R10 program remaining count", 32'(n), 32'(PC - 2));
    rd(40);
    check(rdData == 16'h0000, "R10 resumed program data", 32'(rdData), 0);

    // R13/R14 commands ignored and reads denied while running
    bus(0, 8'h77);
    bus(0, 8'h50);
    prog(7, 16'hAAAA);
    rd(7);
    check(rdDenied == 1'b1, "R13 read denied while busy", 32'(rdDenied), 1);
    bus(0, 8'h60);
    bus(0, 8'h77);
    busyCount(n);
    check(statusReg == 8'h80, "R14 commands ignored while busy", 32'(statusReg), 32'h80);
    prog(8, 16'h5555);
    repeat (PC - 1) @(negedge clk);
    bus(0, 8'hB0);
    check(statusReg == 8'h80, "R14 late suspend ignored", 32'(statusReg), 32'h80);
    rd(8);
    check(rdData == 16'h5555, "R14 op completed", 32'(rdData), 32'h5555);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule